// File: doc/BRIEF.md
# Dual-Path DPLL Reference Input Selector

This block picks which numbered candidate clock input each of two phase-locked paths should track. The primary path has three modes. External fast switching flips between two fixed input pairs under a pin. Forced selection takes one input named by a 4-bit field. Automatic selection takes the best qualified input by priority. The secondary path uses forced or automatic selection in the same way, or it can follow the primary loop's output at one of two rates. Qualification flags come from a separate quality monitor, and the clock multiplexing lies outside the block.

Each path reports a registered input index, a mode code and a no-reference flag. Each path also gives a one-cycle pulse whenever its selection changes. The primary external-switch enable is a register bit. It loads from the fast-switch pin while reset is held, and a write strobe can change it later.

Top module: `dpll_refsel`

## Requirements
- R1: While `rstN` is low, each rising clock edge loads the external-switch bit from `fastSwPin`. After reset it changes only on a cycle with `extSwWe` high, which loads `extSwWrVal`. A value of 1 puts the primary path in fast mode.
- R2: In fast mode, `priSel` and `inQual` have no effect on the primary selection. `priMode` reads 2 and `priNoRef` reads 0.
- R3: In fast mode with `fastSwPin` high, the primary selects input 5 when the priority field of input 3 is zero, and input 3 otherwise. With the pin low, it selects input 6 when input 4's priority field is zero, and input 4 otherwise.
- R4: With the external-switch bit at 0 and `priSel` in 1..NUM_INPUTS, `priRef` equals `priSel` one rising edge later, whatever the qualification. `priMode` reads 1 and `priNoRef` reads 0.
- R5: A forced code above NUM_INPUTS keeps the previous index, sets the no-reference flag and reports mode 1. This applies on either path.
- R6: A select code of 0 means automatic mode (mode 0). The input chosen is the one with `inQual` bit k-1 set and the smallest non-zero priority in `inPrio[4k-1:4k-4]`. A priority of 0 excludes an input, and on a tie the lower index wins.
- R7: In automatic mode with no eligible input, the no-reference flag is 1 and the previous index is kept.
- R8: With `secFollowPri` high, the secondary path reports mode 3, index 0 and no-reference 0. `secRateLow` then equals `secLowRate` (0 for the high-rate output, 1 for the low-rate output), and `secSel` has no effect. In all other modes `secRateLow` is 0.
- R9: When it does not follow the primary, the secondary path applies R4 to R7 to `secSel`. It never enters fast mode, whatever the external-switch bit holds.
- R10: `priSwitch` is high for exactly the cycle in which `priRef` takes a new value. `secSwitch` is high for exactly the cycle in which `secRef` or `secRateLow` changes.
- R11: While reset is held, both indices read 0, both modes read 0, both pulses and `secRateLow` read 0, and both no-reference flags read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| fastSwPin | input | 1 | Strap level for the switch bit during reset; pair choice in fast mode |
| extSwWe | input | 1 | Write strobe for the external-switch bit |
| extSwWrVal | input | 1 | Value written to the external-switch bit |
| priSel | input | 4 | Primary select code (0 = automatic) |
| secSel | input | 4 | Secondary select code (0 = automatic) |
| secFollowPri | input | 1 | Secondary follows the primary loop output |
| secLowRate | input | 1 | Follow rate: 0 high rate, 1 low rate |
| inPrio | input | 4*NUM_INPUTS | Priority code per input, input k at bits 4k-1..4k-4 |
| inQual | input | NUM_INPUTS | Qualification flag per input, input k at bit k-1 |
| priRef | output | 4 | Primary selected input index |
| priMode | output | 2 | Primary mode: 0 auto, 1 forced, 2 fast |
| priNoRef | output | 1 | Primary has no usable reference |
| priSwitch | output | 1 | Primary selection changed this cycle |
| secRef | output | 4 | Secondary selected input index |
| secMode | output | 2 | Secondary mode: 0 auto, 1 forced, 3 follow |
| secNoRef | output | 1 | Secondary has no usable reference |
| secSwitch | output | 1 | Secondary selection or rate changed this cycle |
| secRateLow | output | 1 | Follow rate in use |

## Verification
The bench builds the block with NUM_INPUTS = 8. This leaves 9 to 15 as out-of-range forced codes, and the 256 qualification masks become small enough to sweep in full. Each mask runs under three priority layouts: one with zero codes and ties, one that falls steadily to a zero, and one that is flat. Together these cover exclusion, tie-breaking and the holdover case. The fast pair logic is swept over pin level, both zero tests and several masks and select codes. Two resets, with the strap high and with it low, check the capture.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int CODE_W = 4;

  // Fixed pair members for external fast switching
  localparam logic [CODE_W-1:0] PAIR_HI_MAIN = 4'd3;
  localparam logic [CODE_W-1:0] PAIR_HI_ALT  = 4'd5;
  localparam logic [CODE_W-1:0] PAIR_LO_MAIN = 4'd4;
  localparam logic [CODE_W-1:0] PAIR_LO_ALT  = 4'd6;

  typedef enum logic [1:0] {
    MODE_AUTO   = 2'd0,
    MODE_FORCED = 2'd1,
    MODE_FAST   = 2'd2,
    MODE_FOLLOW = 2'd3
  } selMode_e;

  typedef struct packed {
    logic              load;
    logic [CODE_W-1:0] code;
    selMode_e          mode;
    logic              noRef;
  } pathStrobe_t;

  typedef struct packed {
    pathStrobe_t pri;
    pathStrobe_t sec;
    logic        secRateLow;
  } selStrobe_t;
endpackage

// File: rtl/refsel_search.sv
module refsel_search
  import refsel_pkg::*;
#(
  parameter int NUM_INPUTS = 14
) (
  input  logic [NUM_INPUTS*CODE_W-1:0] inPrio,
  input  logic [NUM_INPUTS-1:0]        inQual,
  output logic                         found,
  output logic [CODE_W-1:0]            bestIdx
);
  logic [CODE_W-1:0] bestPrio;

  // Ascending scan with strict compare: a tie keeps the lower index
  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_INPUTS; i++) begin
      if (inQual[i] && (inPrio[i*CODE_W +: CODE_W] != '0) &&
          (!found || (inPrio[i*CODE_W +: CODE_W] < bestPrio))) begin
        found    = 1'b1;
        bestPrio = inPrio[i*CODE_W +: CODE_W];
        bestIdx  = CODE_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int NUM_INPUTS = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastSwPin,
  input  logic              extSwWe,
  input  logic              extSwWrVal,
  input  logic [CODE_W-1:0] priSel,
  input  logic [CODE_W-1:0] secSel,
  input  logic              secFollowPri,
  input  logic              secLowRate,
  input  logic [CODE_W-1:0] fastPrioHi,
  input  logic [CODE_W-1:0] fastPrioLo,
  input  logic              autoFound,
  input  logic [CODE_W-1:0] autoIdx,
  output selStrobe_t        stb
);
  logic              extSwQ;
  logic [CODE_W-1:0] fastPick;

  // Strap level is loaded on every edge while reset is held
  always_ff @(posedge clk) begin
    if (!rstN)        extSwQ <= fastSwPin;
    else if (extSwWe) extSwQ <= extSwWrVal;
  end

  AST_EXTSW_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !extSwWe |=> $stable(extSwQ)); // R1

  function automatic pathStrobe_t decodeIndep(input logic [CODE_W-1:0] sel,
                                              input logic              hit,
                                              input logic [CODE_W-1:0] idx);
    pathStrobe_t s;
    s.load  = 1'b0;
    s.code  = '0;
    s.noRef = 1'b0;
    s.mode  = MODE_AUTO;
    if (sel == '0) begin
      s.load  = hit;
      s.code  = idx;
      s.noRef = !hit;
    end else begin
      s.mode = MODE_FORCED;
      if (int'(sel) <= NUM_INPUTS) begin
        s.load = 1'b1;
        s.code = sel;
      end else begin
        s.noRef = 1'b1;
      end
    end
    return s;
  endfunction

  always_comb begin
    if (fastSwPin) fastPick = (fastPrioHi == '0) ? PAIR_HI_ALT : PAIR_HI_MAIN;
    else           fastPick = (fastPrioLo == '0) ? PAIR_LO_ALT : PAIR_LO_MAIN;
  end

  always_comb begin
    if (extSwQ) begin
      stb.pri.load  = 1'b1;
      stb.pri.code  = fastPick;
      stb.pri.mode  = MODE_FAST;
      stb.pri.noRef = 1'b0;
    end else begin
      stb.pri = decodeIndep(priSel, autoFound, autoIdx);
    end
    if (secFollowPri) begin
      stb.sec.load   = 1'b1;
      stb.sec.code   = '0;
      stb.sec.mode   = MODE_FOLLOW;
      stb.sec.noRef  = 1'b0;
      stb.secRateLow = secLowRate;
    end else begin
      stb.sec        = decodeIndep(secSel, autoFound, autoIdx);
      stb.secRateLow = 1'b0;
    end
  end
endmodule

// File: rtl/refsel_datapath.sv
module refsel_datapath
  import refsel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  selStrobe_t        stb,
  output logic [CODE_W-1:0] priRef,
  output logic [1:0]        priMode,
  output logic              priNoRef,
  output logic              priSwitch,
  output logic [CODE_W-1:0] secRef,
  output logic [1:0]        secMode,
  output logic              secNoRef,
  output logic              secSwitch,
  output logic              secRateLow
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priRef    <= '0;
      priMode   <= MODE_AUTO;
      priNoRef  <= 1'b1;
      priSwitch <= 1'b0;
    end else begin
      priMode   <= stb.pri.mode;
      priNoRef  <= stb.pri.noRef;
      priSwitch <= stb.pri.load && (stb.pri.code != priRef);
      if (stb.pri.load) priRef <= stb.pri.code;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secRef     <= '0;
      secMode    <= MODE_AUTO;
      secNoRef   <= 1'b1;
      secSwitch  <= 1'b0;
      secRateLow <= 1'b0;
    end else begin
      secMode    <= stb.sec.mode;
      secNoRef   <= stb.sec.noRef;
      secRateLow <= stb.secRateLow;
      secSwitch  <= (stb.sec.load && (stb.sec.code != secRef)) ||
                    (stb.secRateLow != secRateLow);
      if (stb.sec.load) secRef <= stb.sec.code;
    end
  end

  AST_PRI_SWITCH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    priSwitch == (priRef != $past(priRef))); // R10
  AST_SEC_SWITCH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    secSwitch == ({secRef, secRateLow} != $past({secRef, secRateLow}))); // R10
  AST_PRI_HOLD_NOREF: assert property (@(posedge clk) disable iff (!rstN)
    priNoRef |-> $stable(priRef)); // R7
  AST_FAST_PAIR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (priMode == MODE_FAST) |-> ((priRef >= 4'd3) && (priRef <= 4'd6))); // R3
  AST_FOLLOW_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (secMode == MODE_FOLLOW) |-> ((secRef == '0) && !secNoRef)); // R8
  AST_SEC_NEVER_FAST: assert property (@(posedge clk) disable iff (!rstN)
    secMode != MODE_FAST); // R9
endmodule

// File: rtl/dpll_refsel.sv
module dpll_refsel
  import refsel_pkg::*;
#(
  parameter int NUM_INPUTS = 14
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fastSwPin,
  input  logic                         extSwWe,
  input  logic                         extSwWrVal,
  input  logic [CODE_W-1:0]            priSel,
  input  logic [CODE_W-1:0]            secSel,
  input  logic                         secFollowPri,
  input  logic                         secLowRate,
  input  logic [NUM_INPUTS*CODE_W-1:0] inPrio,
  input  logic [NUM_INPUTS-1:0]        inQual,
  output logic [CODE_W-1:0]            priRef,
  output logic [1:0]                   priMode,
  output logic                         priNoRef,
  output logic                         priSwitch,
  output logic [CODE_W-1:0]            secRef,
  output logic [1:0]                   secMode,
  output logic                         secNoRef,
  output logic                         secSwitch,
  output logic                         secRateLow
);
  localparam int HI_BASE = (int'(PAIR_HI_MAIN) - 1) * CODE_W;
  localparam int LO_BASE = (int'(PAIR_LO_MAIN) - 1) * CODE_W;

  if (NUM_INPUTS < 6 || NUM_INPUTS > 15) begin : g_badCount
    $error("NUM_INPUTS must lie in 6..15");
  end

  logic              autoFound;
  logic [CODE_W-1:0] autoIdx;
  selStrobe_t        stb;

  refsel_search #(.NUM_INPUTS(NUM_INPUTS)) i_search (
    .inPrio  (inPrio),
    .inQual  (inQual),
    .found   (autoFound),
    .bestIdx (autoIdx)
  );

  refsel_ctrl #(.NUM_INPUTS(NUM_INPUTS)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fastSwPin    (fastSwPin),
    .extSwWe      (extSwWe),
    .extSwWrVal   (extSwWrVal),
    .priSel       (priSel),
    .secSel       (secSel),
    .secFollowPri (secFollowPri),
    .secLowRate   (secLowRate),
    .fastPrioHi   (inPrio[HI_BASE +: CODE_W]),
    .fastPrioLo   (inPrio[LO_BASE +: CODE_W]),
    .autoFound    (autoFound),
    .autoIdx      (autoIdx),
    .stb          (stb)
  );

  refsel_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .priRef     (priRef),
    .priMode    (priMode),
    .priNoRef   (priNoRef),
    .priSwitch  (priSwitch),
    .secRef     (secRef),
    .secMode    (secMode),
    .secNoRef   (secNoRef),
    .secSwitch  (secSwitch),
    .secRateLow (secRateLow)
  );
endmodule

// File: tb/test_dpll_refsel.sv
`timescale 1ns/1ps
module test_dpll_refsel;
  localparam int NI = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, fastSwPin = 1'b0, extSwWe = 1'b0, extSwWrVal = 1'b0;
  logic secFollowPri = 1'b0, secLowRate = 1'b0;
  logic [3:0] priSel = '0, secSel = '0;
  logic [NI*4-1:0] inPrio = '0;
  logic [NI-1:0] inQual = '0;
  logic [3:0] priRef, secRef;
  logic [1:0] priMode, secMode;
  logic priNoRef, priSwitch, secNoRef, secSwitch, secRateLow;

  int nChecks = 0, nFails = 0;
  int lastPri = 0, lastSec = 0, lastRate = 0;
  bit extModel = 1'b0, done = 1'b0;

  dpll_refsel #(.NUM_INPUTS(NI)) i_dpll_refsel (
    .clk(clk), .rstN(rstN), .fastSwPin(fastSwPin), .extSwWe(extSwWe),
    .extSwWrVal(extSwWrVal), .priSel(priSel), .secSel(secSel),
    .secFollowPri(secFollowPri), .secLowRate(secLowRate), .inPrio(inPrio),
    .inQual(inQual), .priRef(priRef), .priMode(priMode), .priNoRef(priNoRef),
    .priSwitch(priSwitch), .secRef(secRef), .secMode(secMode),
    .secNoRef(secNoRef), .secSwitch(secSwitch), .secRateLow(secRateLow)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic setPrio(int k, int v);
    inPrio[(k-1)*4 +: 4] = 4'(v);
  endtask

  task automatic modelIndep(input int sel, input int held,
                            output int r, output int m, output int nr);
    int bestP = 16;
    int bestK = 0;
    for (int k = 1; k <= NI; k++) begin
      int p = int'(inPrio[(k-1)*4 +: 4]);
      if (inQual[k-1] && p != 0 && p < bestP) begin
        bestP = p;
        bestK = k;
      end
    end
    if (sel == 0) begin
      m = 0;
      r = (bestK != 0) ? bestK : held;
      nr = (bestK == 0) ? 1 : 0;
    end else begin
      m = 1;
      r = (sel <= NI) ? sel : held;
      nr = (sel <= NI) ? 0 : 1;
    end
  endtask

  task automatic stepCheck(string tag);
    int ePri, ePriMode, ePriNR, eSec, eSecMode, eSecNR, eRate;
    if (extModel) begin
      ePriMode = 2;
      ePriNR = 0;
      if (fastSwPin) ePri = (inPrio[8 +: 4] == 0) ? 5 : 3;
      else           ePri = (inPrio[12 +: 4] == 0) ? 6 : 4;
    end else begin
      modelIndep(int'(priSel), lastPri, ePri, ePriMode, ePriNR);
    end
    if (secFollowPri) begin
      eSec = 0; eSecMode = 3; eSecNR = 0; eRate = int'(secLowRate);
    end else begin
      modelIndep(int'(secSel), lastSec, eSec, eSecMode, eSecNR);
      eRate = 0;
    end
    @(posedge clk); #1;
    chk(tag, "priRef", int'(priRef), ePri);
    chk(tag, "priMode", int'(priMode), ePriMode);
    chk(tag, "priNoRef", int'(priNoRef), ePriNR);
    chk(tag, "secRef", int'(secRef), eSec);
    chk(tag, "secMode", int'(secMode), eSecMode);
    chk(tag, "secNoRef", int'(secNoRef), eSecNR);
    chk(tag, "secRateLow", int'(secRateLow), eRate);
    chk("R10", "priSwitch", int'(priSwitch), int'(ePri != lastPri));
    chk("R10", "secSwitch", int'(secSwitch), int'((eSec != lastSec) || (eRate != lastRate)));
    lastPri = ePri; lastSec = eSec; lastRate = eRate;
    @(posedge clk); #1;
    chk("R10", "priSwitch idle", int'(priSwitch), 0);
    chk("R10", "secSwitch idle", int'(secSwitch), 0);
    chk(tag, "priRef kept", int'(priRef), ePri);
  endtask

  task automatic doReset(bit strap);
    @(negedge clk);
    rstN = 1'b0; fastSwPin = strap; extSwWe = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "priRef", int'(priRef), 0);
    chk("R11", "secRef", int'(secRef), 0);
    chk("R11", "priMode", int'(priMode), 0);
    chk("R11", "secMode", int'(secMode), 0);
    chk("R11", "priNoRef", int'(priNoRef), 1);
    chk("R11", "secNoRef", int'(secNoRef), 1);
    chk("R11", "switches", int'(priSwitch) + int'(secSwitch), 0);
    chk("R11", "secRateLow", int'(secRateLow), 0);
    @(negedge clk);
    rstN = 1'b1;
    extModel = strap;
    lastPri = 0; lastSec = 0; lastRate = 0;
  endtask

  task automatic writeExt(bit v);
    @(negedge clk);
    extSwWe = 1'b1; extSwWrVal = v;
    @(negedge clk);
    extSwWe = 1'b0;
    extModel = v;
  endtask

  initial begin
    #800000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    doReset(1'b1);
    for (int k = 1; k <= NI; k++) setPrio(k, k);
    stepCheck("R1");
    // fast pair sweep: pin, zero tests, masks, select codes
    for (int pin = 0; pin < 2; pin++)
      for (int z3 = 0; z3 < 2; z3++)
        for (int z4 = 0; z4 < 2; z4++)
          for (int m = 0; m < 3; m++)
            for (int ps = 0; ps < 2; ps++) begin
              fastSwPin = pin[0];
              setPrio(3, (z3 != 0) ? 0 : 9);
              setPrio(4, (z4 != 0) ? 0 : 11);
              inQual = (m == 0) ? 8'h00 : ((m == 1) ? 8'hFF : 8'h5A);
              priSel = (ps != 0) ? 4'd5 : 4'd0;
              stepCheck("R2/R3");
            end
    writeExt(1'b0);
    stepCheck("R1");
    // forced codes in and out of range on both paths
    inQual = '0;
    for (int c = 1; c <= 15; c++) begin
      priSel = 4'(c);
      secSel = 4'(16 - c);
      stepCheck("R4/R5/R9");
    end
    // automatic: every mask under three priority layouts
    priSel = '0; secSel = '0;
    for (int seed = 0; seed < 3; seed++) begin
      for (int k = 1; k <= NI; k++)
        setPrio(k, (seed == 0) ? ((k*3 + 1) % 4) : ((seed == 1) ? (8 - k) : 5));
      for (int m = 0; m < 256; m++) begin
        inQual = 8'(m);
        stepCheck("R6/R7/R9");
      end
    end
    // secondary following the primary loop output
    inQual = 8'hFF; secSel = 4'd2; secFollowPri = 1'b1; secLowRate = 1'b0;
    stepCheck("R8");
    secLowRate = 1'b1;
    stepCheck("R8");
    secLowRate = 1'b0;
    stepCheck("R8");
    secFollowPri = 1'b0;
    stepCheck("R9");
    writeExt(1'b1);
    stepCheck("R9");
    doReset(1'b0);
    stepCheck("R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule